// File: doc/BRIEF.md
# Configuration-Space Window Translator

This block sits between a big-endian CPU load/store path and a little-endian PCI configuration port. The CPU accesses a fixed 4 MiB region of physical address space. The block accepts only accesses that fall inside that region. It finds the target device from a one-hot select field in the address and forms a compact configuration address from it. It then issues one configuration transaction on a valid/ready request port and waits for read data when needed. Data is byte-reversed in both directions for 16-bit and 32-bit accesses.

The CPU starts an access with a one-cycle `cpu_req` pulse. It then watches `cpu_busy` and the one-cycle `cpu_done` pulse that ends the access. Accesses that fall outside the window are not acknowledged at all, so some other decoder is expected to answer them.

A small side function routes device interrupts. A device's interrupt pin is swizzled with its slot number onto one of two shared lines, and those two lines drive interrupt-controller inputs 9 and 11.

Top module: `cfg_window_xlate`

## Requirements
- R1: An access whose address lies in 0x8080_0000..0x80BF_FFFF is accepted. An access outside that range leaves `cpu_busy` low and raises no `cfg_valid`.
- R2: The device number is the index (0..10) of the lowest set bit among address bits 21..11, counting from bit 11 upward. When none of those bits is set, the device number is 11.
- R3: `cfg_addr` is 15 bits wide. Bits 14..11 hold the device number and bits 10..0 hold address bits 10..0.
- R4: The `cpu_size` encoding is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. Write data goes out as follows: a byte as bits 7..0; a halfword with bytes 0 and 1 exchanged; a word with all four bytes reversed. Unused upper lanes are zero.
- R5: Read data returned on `cpu_rdata` uses the same byte ordering as R4, applied to `cfg_rdata`, and is zero-extended above the access size.
- R6: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid`, `cfg_addr`, `cfg_we`, `cfg_size` and `cfg_wdata` hold steady. Only one transaction is in flight, and `cpu_req` is ignored while `cpu_busy` is high.
- R7: `cpu_done` is a one-cycle pulse. For a write it comes in the cycle after the `cfg_valid`/`cfg_ready` handshake. For a read it comes in the cycle after `cfg_rvalid`.
- R8: The interrupt line is (`irq_pin` + `irq_devfn`[7:3]) modulo 2.
- R9: On an `irq_strobe` cycle, line 1 copies `irq_level` to `intc_in11` and line 0 copies it to `intc_in9`, one cycle later. The other output and all cycles without a strobe leave both outputs unchanged.
- R10: Synchronous active-high `rst` returns the block to idle. It clears `cfg_valid`, `cpu_busy`, `cpu_done`, `intc_in9` and `intc_in11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access start pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data, low lanes used |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | Access complete pulse |
| cpu_rdata | output | 32 | Swapped, zero-extended read data |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration request accepted |
| cfg_we | output | 1 | Request is a write |
| cfg_size | output | 2 | Request size code |
| cfg_addr | output | 15 | Device number and register offset |
| cfg_wdata | output | 32 | Bus-order write data |
| cfg_rvalid | input | 1 | Read response valid |
| cfg_rdata | input | 32 | Bus-order read data |
| irq_strobe | input | 1 | Apply an interrupt level change |
| irq_devfn | input | 8 | Device/function number of the source |
| irq_pin | input | 2 | Interrupt pin number of the source |
| irq_level | input | 1 | New level |
| intc_in9 | output | 1 | Controller input 9 (line 0) |
| intc_in11 | output | 1 | Controller input 11 (line 1) |

## Verification
The assertions check several rules on every cycle. They check that a stalled request holds its fields and that misses never start a transaction. They check that the device number never exceeds 11 and that `cpu_done` follows its triggering handshake or response by exactly one cycle. They also check that the interrupt outputs move only on a strobe and that reset clears everything. Other results depend on actual data values and can only be shown by the bench's scenarios. These are the value of the device number for a given select pattern, the exact byte order per size, zero extension of narrow reads, the swizzle arithmetic, and the window edges at the first and last byte. The bench reaches these with random one-hot patterns and random responder stalls.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2,
    XS_DONE  = 2'd3
  } xact_state_t;

  // Reorder bytes between big-endian CPU lanes and little-endian bus lanes.
  // Size code: 0 = byte, 1 = halfword, 2/3 = word. Upper lanes zeroed.
  function automatic logic [31:0] lane_swap(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    case (sz)
      2'd0:    r = {24'h0, d[7:0]};
      2'd1:    r = {16'h0, d[7:0], d[15:8]};
      default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
    return r;
  endfunction

  // Shared interrupt line: (pin + slot) mod 2, slot = devfn >> 3.
  function automatic logic irq_line(input logic [1:0] pin, input logic [7:0] devfn);
    logic [7:0] s;
    s = 8'(pin) + (devfn >> 3);
    return s[0];
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_AW = 22,
  parameter int OFF_W  = 11,
  parameter int SEL_W  = 11,
  localparam int DEV_W = $clog2(SEL_W + 1),
  localparam int CA_W  = OFF_W + DEV_W
) (
  input  logic [31:0]     addr,
  output logic            win_hit,
  output logic [DEV_W-1:0] dev_num,
  output logic [CA_W-1:0] cfg_addr
);

  logic [SEL_W-1:0] sel_field;

  assign win_hit   = (addr[31:WIN_AW] == WIN_BASE[31:WIN_AW]);
  assign sel_field = addr[OFF_W+SEL_W-1:OFF_W];

  // Lowest set bit wins; scan from the top so the last hit is the lowest.
  always_comb begin
    dev_num = DEV_W'(SEL_W);
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (sel_field[i]) dev_num = DEV_W'(i);
    end
  end

  assign cfg_addr = {dev_num, addr[OFF_W-1:0]};

endmodule

// File: rtl/cfgx_xact.sv
module cfgx_xact
  import cfgx_pkg::*;
#(
  parameter int CA_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            st_we,
  input  logic [1:0]      st_size,
  input  logic [CA_W-1:0] st_addr,
  input  logic [31:0]     st_wdata,
  output logic            cfg_valid,
  input  logic            cfg_ready,
  output logic            cfg_we,
  output logic [1:0]      cfg_size,
  output logic [CA_W-1:0] cfg_addr,
  output logic [31:0]     cfg_wdata,
  input  logic            cfg_rvalid,
  input  logic [31:0]     cfg_rdata,
  output logic            busy,
  output logic            done,
  output logic [31:0]     rdata
);

  xact_state_t state;
  logic        hs_fire;
  logic        rsp_fire;

  assign cfg_valid = (state == XS_ISSUE);
  assign busy      = (state != XS_IDLE);
  assign done      = (state == XS_DONE);
  assign hs_fire   = cfg_valid && cfg_ready;
  assign rsp_fire  = (state == XS_WAIT) && cfg_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      cfg_we    <= 1'b0;
      cfg_size  <= 2'd0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
      rdata     <= '0;
    end else begin
      case (state)
        XS_IDLE: if (start) begin
          cfg_we    <= st_we;
          cfg_size  <= st_size;
          cfg_addr  <= st_addr;
          cfg_wdata <= lane_swap(st_wdata, st_size);
          state     <= XS_ISSUE;
        end
        XS_ISSUE: if (cfg_ready) state <= cfg_we ? XS_DONE : XS_WAIT;
        XS_WAIT: if (cfg_rvalid) begin
          rdata <= lane_swap(cfg_rdata, cfg_size);
          state <= XS_DONE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  // R6: a stalled request keeps every field steady
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_wdata)
      && $stable(cfg_we) && $stable(cfg_size));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_write_done_R7: assert property (@(posedge clk) disable iff (rst)
    hs_fire && cfg_we |=> done);

  assert_read_done_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_fire |=> done);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !busy && !cfg_valid && !done);

endmodule

// File: rtl/cfgx_irq_route.sv
module cfgx_irq_route
  import cfgx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_strobe,
  input  logic [7:0] irq_devfn,
  input  logic [1:0] irq_pin,
  input  logic       irq_level,
  output logic       intc_in9,
  output logic       intc_in11
);

  logic line_sel;

  assign line_sel = irq_line(irq_pin, irq_devfn);

  always_ff @(posedge clk) begin
    if (rst) begin
      intc_in9  <= 1'b0;
      intc_in11 <= 1'b0;
    end else if (irq_strobe) begin
      if (line_sel) intc_in11 <= irq_level;
      else          intc_in9  <= irq_level;
    end
  end

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_strobe |=> $stable(intc_in9) && $stable(intc_in11));

  assert_irq_one_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq_strobe |=> $stable(intc_in9) || $stable(intc_in11));

  assert_irq_reset_R10: assert property (@(posedge clk)
    rst |=> !intc_in9 && !intc_in11);

endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_AW = 22,
  parameter int OFF_W  = 11,
  parameter int SEL_W  = 11,
  localparam int DEV_W = $clog2(SEL_W + 1),
  localparam int CA_W  = OFF_W + DEV_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [1:0]      cpu_size,
  input  logic [31:0]     cpu_addr,
  input  logic [31:0]     cpu_wdata,
  output logic            cpu_busy,
  output logic            cpu_done,
  output logic [31:0]     cpu_rdata,
  output logic            cfg_valid,
  input  logic            cfg_ready,
  output logic            cfg_we,
  output logic [1:0]      cfg_size,
  output logic [CA_W-1:0] cfg_addr,
  output logic [31:0]     cfg_wdata,
  input  logic            cfg_rvalid,
  input  logic [31:0]     cfg_rdata,
  input  logic            irq_strobe,
  input  logic [7:0]      irq_devfn,
  input  logic [1:0]      irq_pin,
  input  logic            irq_level,
  output logic            intc_in9,
  output logic            intc_in11
);

  logic             win_hit;
  logic [DEV_W-1:0] dev_num;
  logic [CA_W-1:0]  dec_addr;
  logic             xact_start;

  cfgx_decode #(
    .WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW), .OFF_W(OFF_W), .SEL_W(SEL_W)
  ) u_decode (
    .addr(cpu_addr), .win_hit(win_hit), .dev_num(dev_num), .cfg_addr(dec_addr)
  );

  assign xact_start = cpu_req && win_hit && !cpu_busy;

  cfgx_xact #(.CA_W(CA_W)) u_xact (
    .clk(clk), .rst(rst), .start(xact_start),
    .st_we(cpu_we), .st_size(cpu_size), .st_addr(dec_addr), .st_wdata(cpu_wdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
    .cfg_size(cfg_size), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .busy(cpu_busy), .done(cpu_done), .rdata(cpu_rdata)
  );

  cfgx_irq_route u_irq (
    .clk(clk), .rst(rst), .irq_strobe(irq_strobe), .irq_devfn(irq_devfn),
    .irq_pin(irq_pin), .irq_level(irq_level),
    .intc_in9(intc_in9), .intc_in11(intc_in11)
  );

  assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_busy && !win_hit |=> !cpu_busy);

  assert_hit_taken_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_busy && win_hit |=> cfg_valid);

  assert_dev_range_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> cfg_addr[CA_W-1:OFF_W] <= DEV_W'(SEL_W));

  // R6: a request arriving mid-transaction does not restart the sequence
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_busy && !cpu_done |=> cpu_busy);

endmodule

// File: tb/cfg_window_xlate_tb.sv
module cfg_window_xlate_tb;

  localparam logic [31:0] BASE = 32'h8080_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [1:0]  cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        cfg_valid, cfg_we;
  logic        cfg_ready = 0, cfg_rvalid = 0;
  logic [1:0]  cfg_size;
  logic [14:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = 0;
  logic        irq_strobe = 0, irq_level = 0;
  logic [7:0]  irq_devfn = 0;
  logic [1:0]  irq_pin = 0;
  logic        intc_in9, intc_in11;

  int errors = 0, checks = 0;
  int cyc = 0;
  bit finished = 0;

  // captured request and response bookkeeping
  logic [14:0] cap_addr;
  logic [31:0] cap_wdata, rsp_raw;
  logic        cap_we;
  logic [1:0]  cap_size;
  int          hs_cyc, rv_cyc, n_hs = 0;
  logic        m9 = 0, m11 = 0;

  cfg_window_xlate u_dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dev(input logic [31:0] a);
    logic [10:0] f;
    int n;
    f = a[21:11];
    n = 0;
    while (n < 11 && f[0] == 1'b0) begin
      f = f >> 1;
      n++;
    end
    return 4'(n);
  endfunction

  function automatic logic [31:0] exp_swap(input logic [31:0] d, input logic [1:0] sz);
    int nb;
    logic [31:0] r;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    r = 0;
    for (int k = 0; k < nb; k++) r[8*(nb-1-k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  // Bus-side responder with random stalls and response latency
  initial begin
    bit rd_pend = 0, stalled = 0;
    int rv_wait = 0;
    logic [14:0] st_addr;
    logic [31:0] st_wdata;
    forever begin
      @(negedge clk);
      cfg_rvalid = 0;
      if (rst) begin
        cfg_ready = 0; rd_pend = 0; stalled = 0;
      end else begin
        if (cfg_ready) begin
          cfg_ready = 0;
          if (!cap_we) begin rd_pend = 1; rv_wait = $urandom % 3; end
        end else if (cfg_valid) begin
          if (stalled)
            check(cfg_addr == st_addr && cfg_wdata == st_wdata, "R6", "stall hold",
                  {17'h0, cfg_addr}, {17'h0, st_addr});
          if ($urandom % 3 != 0) begin
            cfg_ready = 1; stalled = 0;
            cap_addr = cfg_addr; cap_wdata = cfg_wdata;
            cap_we = cfg_we; cap_size = cfg_size;
            hs_cyc = cyc; n_hs++;
          end else begin
            stalled = 1; st_addr = cfg_addr; st_wdata = cfg_wdata;
          end
        end
        if (rd_pend) begin
          if (rv_wait == 0) begin
            cfg_rvalid = 1; cfg_rdata = $urandom; rsp_raw = cfg_rdata;
            rv_cyc = cyc; rd_pend = 0;
          end else rv_wait--;
        end
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit we,
                        input logic [31:0] wd);
    bit hit;
    int hs0;
    hit = (a >= BASE) && (a <= BASE + 32'h003F_FFFF);
    hs0 = n_hs;
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    if (!hit) begin
      for (int k = 0; k < 4; k++) begin
        check(!cpu_busy && !cfg_valid, "R1", "miss ignored", {31'h0, cpu_busy}, 0);
        @(negedge clk);
      end
      check(n_hs == hs0, "R1", "no handshake on miss", n_hs, hs0);
      return;
    end
    for (int k = 0; k < 60 && !cpu_done; k++) @(negedge clk);
    check(cpu_done, "R1", "hit completes", {31'h0, cpu_done}, 1);
    check(cap_addr[14:11] == exp_dev(a), "R2", "device number", cap_addr[14:11], exp_dev(a));
    check(cap_addr == {exp_dev(a), a[10:0]}, "R3", "cfg address", cap_addr, {exp_dev(a), a[10:0]});
    check(cap_we == we && cap_size == sz, "R6", "command fields", {cap_we, cap_size}, {we, sz});
    if (we) begin
      check(cap_wdata == exp_swap(wd, sz), "R4", "write lanes", cap_wdata, exp_swap(wd, sz));
      check(cyc == hs_cyc + 1, "R7", "write done timing", cyc, hs_cyc + 1);
    end else begin
      check(cpu_rdata == exp_swap(rsp_raw, sz), "R5", "read lanes", cpu_rdata, exp_swap(rsp_raw, sz));
      check(cyc == rv_cyc + 1, "R7", "read done timing", cyc, rv_cyc + 1);
    end
    @(negedge clk);
    check(!cpu_done, "R7", "done is one pulse", {31'h0, cpu_done}, 0);
  endtask

  task automatic irq_set(input logic [1:0] pin, input logic [7:0] devfn, input logic lvl);
    logic [7:0] slot;
    @(negedge clk);
    irq_strobe = 1; irq_pin = pin; irq_devfn = devfn; irq_level = lvl;
    slot = devfn / 8;
    if (((int'(pin) + int'(slot)) % 2) == 1) m11 = lvl; else m9 = lvl;
    @(negedge clk);
    irq_strobe = 0; irq_level = ~lvl;
    check(intc_in9 == m9 && intc_in11 == m11, "R8", "swizzled line",
          {30'h0, intc_in11, intc_in9}, {30'h0, m11, m9});
    @(negedge clk);
    check(intc_in9 == m9 && intc_in11 == m11, "R9", "no strobe no change",
          {30'h0, intc_in11, intc_in9}, {30'h0, m11, m9});
  endtask

  function automatic logic [31:0] rand_win_addr();
    int k;
    logic [10:0] sel;
    k = $urandom % 12;
    if (k == 11) sel = 0;
    else begin
      sel = 11'($urandom);
      sel = (sel & ~((11'd1 << k) - 11'd1)) | (11'd1 << k);
    end
    return BASE | {10'h0, sel, 11'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!cpu_busy && !cfg_valid && !cpu_done && !intc_in9 && !intc_in11, "R10",
          "reset state", {27'h0, cpu_busy, cfg_valid, cpu_done, intc_in9, intc_in11}, 0);
    rst = 0;
    // directed corners: window edges, empty select, each end of the select field
    access(BASE, 2'd2, 1, 32'h1122_3344);
    access(BASE + 32'h003F_FFFF, 2'd0, 0, 0);
    access(BASE - 1, 2'd2, 1, 32'hDEAD_BEEF);
    access(BASE + 32'h0040_0000, 2'd1, 0, 0);
    access(BASE | 32'h0000_0800 | 32'h0020_0000, 2'd1, 1, 32'h0000_A1B2);
    access(BASE | 32'h0020_0004, 2'd2, 0, 0);
    access(BASE | 32'h0001_8010, 2'd1, 0, 0);
    access(BASE | 32'h0000_0123, 2'd0, 1, 32'hFFFF_FF5A);
    access(BASE | 32'h0004_0000, 2'd3, 1, 32'hCAFE_F00D);
    for (int i = 0; i < 60; i++)
      access(($urandom % 8 == 0) ? 32'($urandom) : rand_win_addr(),
             2'($urandom), 1'($urandom), $urandom);
    // R6: a request while busy must not start a second transaction
    begin
      int hs0;
      hs0 = n_hs;
      @(negedge clk);
      cpu_req = 1; cpu_addr = BASE | 32'h800; cpu_size = 2; cpu_we = 0;
      @(negedge clk);
      cpu_addr = BASE | 32'h1000; cpu_we = 1;
      @(negedge clk);
      cpu_req = 0;
      for (int k = 0; k < 60 && !cpu_done; k++) @(negedge clk);
      repeat (6) @(negedge clk);
      check(n_hs == hs0 + 1, "R6", "one transaction only", n_hs, hs0 + 1);
      check(cap_addr == 15'h0000 && !cap_we, "R6", "first request kept",
            {16'h0, cap_we, cap_addr}, 0);
    end
    // interrupts
    irq_set(2'd0, 8'h00, 1);
    irq_set(2'd1, 8'h00, 1);
    irq_set(2'd0, 8'h08, 0);
    irq_set(2'd3, 8'h10, 0);
    for (int i = 0; i < 24; i++) irq_set(2'($urandom), 8'($urandom), 1'($urandom));
    irq_set(2'd1, 8'h18, 1);
    irq_set(2'd2, 8'h18, 1);
    // reset in the middle of a read
    @(negedge clk);
    cpu_req = 1; cpu_addr = BASE; cpu_size = 2; cpu_we = 0;
    @(negedge clk);
    cpu_req = 0; rst = 1;
    @(negedge clk);
    m9 = 0; m11 = 0;
    check(!cpu_busy && !cfg_valid && !intc_in9 && !intc_in11, "R10", "mid-run reset",
          {28'h0, cpu_busy, cfg_valid, intc_in9, intc_in11}, 0);
    rst = 0;
    access(BASE | 32'h0000_2004, 2'd2, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule